// File: doc/BRIEF.md
# Banked Masked-Write Control Register File

This block holds the system control registers of a small multithreaded core. Software reaches a register through a 5-bit register number and a 3-bit select, which combine into a flat slot `num*8 + sel`. A normal write changes only the bits that are writable in that register; every other bit keeps its stored value. A separate raw-write strobe stores the full word. It exists for initialisation code that must load fields software cannot normally change.

Some registers have one copy per hardware thread, chosen by the thread id of the access. Some have one copy per virtual execution element (VE), chosen by the VE field held in the accessing thread's binding register. The rest are single shared copies. The block loads defined reset values. One cycle after any write to an implemented slot, it works out again whether each thread may run, and it drives one run-enable bit per thread.

Top module: `cop_ctrl_regfile`

## Requirements
- R1: A normal write to an implemented slot stores `(wdata & mask) | (old & ~mask)`. Masks by slot (num,sel): status (12,0) 0xFF78FF17, vector base (15,1) 0x3FFFF000, cfg0 (16,0) 0x7FFF0007, cfg2 (16,2) 0x7000F000, irq control (12,1) 0x000003E0, shadow control (12,2) 0x0000F3C0, page granule (5,1) 0x10000000, tlb index (0,0) 0x7FFFFFFF. The per-thread slots, the per-VE slots and the shared debug-free slots not listed here are fully writable.
- R2: The CPU id (15,0), cfg1 (16,1), cfg3 (16,3), random index (1,0) and topology (0,2) slots have mask 0, so a normal write leaves them unchanged.
- R3: A write with `raw_wr` high stores `wdata` unmasked into any implemented slot.
- R4: The per-thread slots each hold one copy per thread and are selected by `tid`: status (12,0), thread state (2,1), thread binding (2,2), thread stop (2,4), link address (17,0) and debug control (23,0).
- R5: The per-VE slots each hold one copy per VE: VE control (1,1), VE config (1,2) and shadow config (6,1). They are selected by the low `$clog2(NVES)` bits of the accessing thread's binding register, bits [3:0].
- R6: The reset values are as follows. Status is 0x10400004 in every thread. Vector base is 0x80000000. Random index is 63. CPU id is the parameter `CPU_ID`. The topology slot holds NTHREADS-1 in bits [7:0] and NVES-1 in bits [13:10]. Every other slot resets to 0.
- R7: At reset, thread 0's state has the active bit (bit 13) set. Every other thread's state has the dynamic-allocation bit (bit 15) set. `run_en` resets to 1 for thread 0 only.
- R8: A thread runs when the stop bit (bit 0 of its stop slot) is 0 and its active bit is 1; otherwise it is halted. `run_en` is updated at the second clock edge after a write is presented, and at no other time.
- R9: Only threads whose index is at most topology bits [7:0] are evaluated again; the other threads keep their `run_en` value.
- R10: Unimplemented slots read as 0, and writes to them are ignored.
- R11: `rdata` is loaded on the clock edge where `rd_en` is high and holds its value otherwise. A read in the same cycle as a write returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tid | input | TID_W | Thread id of the access |
| reg_num | input | 5 | Register number |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe |
| raw_wr | input | 1 | Write bypasses the mask |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| run_en | output | NTHREADS | Per-thread run enable |

## Verification
The assertions check on every cycle that a masked write leaves the protected bits unchanged and takes the writable bits from `wdata`. They also check that a raw write is stored unmasked, that unimplemented slots read zero, that `rdata` holds when no read is made, and that `run_en` never moves unless a write was made two cycles earlier. The bench scenarios show the things a single cycle cannot. These are the bank a per-VE access lands in after a thread's binding has changed, the separation between per-thread copies, the reset contents, and the effect of a reduced thread count in the topology slot.

// File: rtl/cop_regs_pkg.sv
package cop_regs_pkg;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_SHARED = 2'd1,
        BK_THREAD = 2'd2,
        BK_VE     = 2'd3
    } bank_e;

    typedef struct packed {
        bank_e       bank;
        logic [3:0]  idx;
        logic [31:0] mask;
    } slot_t;

    localparam int N_SHARED = 12;
    localparam int N_THREAD = 6;
    localparam int N_VEREG  = 3;

    // local indices used by the top
    localparam int SH_TOPO   = 1;
    localparam int SH_RAND   = 2;
    localparam int SH_CPUID  = 6;
    localparam int SH_VBASE  = 7;
    localparam int TH_STATUS = 0;
    localparam int TH_STATE  = 1;
    localparam int TH_BIND   = 2;
    localparam int TH_STOP   = 3;

    localparam int ACT_BIT  = 13;
    localparam int DYN_BIT  = 15;
    localparam int STOP_BIT = 0;
    localparam int VE_LO    = 10;

    localparam logic [31:0] STATUS_RST = 32'h1040_0004;
    localparam logic [31:0] VBASE_RST  = 32'h8000_0000;
    localparam logic [31:0] FULL       = 32'hFFFF_FFFF;

    function automatic slot_t slot_lookup(input logic [7:0] flat);
        slot_t s;
        s = '{bank: BK_NONE, idx: 4'd0, mask: 32'h0};
        case (flat)
            8'd0:   s = '{BK_SHARED, 4'd0,  32'h7FFF_FFFF};
            8'd2:   s = '{BK_SHARED, 4'd1,  32'h0};
            8'd8:   s = '{BK_SHARED, 4'd2,  32'h0};
            8'd41:  s = '{BK_SHARED, 4'd3,  32'h1000_0000};
            8'd97:  s = '{BK_SHARED, 4'd4,  32'h0000_03E0};
            8'd98:  s = '{BK_SHARED, 4'd5,  32'h0000_F3C0};
            8'd120: s = '{BK_SHARED, 4'd6,  32'h0};
            8'd121: s = '{BK_SHARED, 4'd7,  32'h3FFF_F000};
            8'd128: s = '{BK_SHARED, 4'd8,  32'h7FFF_0007};
            8'd129: s = '{BK_SHARED, 4'd9,  32'h0};
            8'd130: s = '{BK_SHARED, 4'd10, 32'h7000_F000};
            8'd131: s = '{BK_SHARED, 4'd11, 32'h0};
            8'd96:  s = '{BK_THREAD, 4'd0,  32'hFF78_FF17};
            8'd17:  s = '{BK_THREAD, 4'd1,  FULL};
            8'd18:  s = '{BK_THREAD, 4'd2,  FULL};
            8'd20:  s = '{BK_THREAD, 4'd3,  FULL};
            8'd136: s = '{BK_THREAD, 4'd4,  FULL};
            8'd184: s = '{BK_THREAD, 4'd5,  FULL};
            8'd9:   s = '{BK_VE,     4'd0,  FULL};
            8'd10:  s = '{BK_VE,     4'd1,  FULL};
            8'd49:  s = '{BK_VE,     4'd2,  FULL};
            default: s = '{bank: BK_NONE, idx: 4'd0, mask: 32'h0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cop_slot_decode.sv
module cop_slot_decode
    import cop_regs_pkg::*;
(
    input  logic [4:0] reg_num,
    input  logic [2:0] reg_sel,
    output slot_t      slot
);
    always_comb slot = slot_lookup({reg_num, reg_sel});
endmodule

// File: rtl/cop_mask_merge.sv
module cop_mask_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mask,
    input  logic          raw,
    output logic [DW-1:0] merged
);
    always_comb begin
        if (raw) merged = wdata;
        else     merged = (wdata & mask) | (cur & ~mask);
    end
endmodule

// File: rtl/cop_run_eval.sv
module cop_run_eval #(
    parameter int NTHREADS = 4
) (
    input  logic                eval,
    input  logic [7:0]          last_tid,
    input  logic [NTHREADS-1:0] act,
    input  logic [NTHREADS-1:0] stop,
    input  logic [NTHREADS-1:0] run_q,
    output logic [NTHREADS-1:0] run_d
);
    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        always_comb begin
            if (eval && (t <= int'(last_tid))) run_d[t] = act[t] && !stop[t];
            else                                run_d[t] = run_q[t];
        end
    end
endmodule

// File: rtl/cop_ctrl_regfile.sv
module cop_ctrl_regfile
    import cop_regs_pkg::*;
#(
    parameter int          NTHREADS = 4,
    parameter int          NVES     = 2,
    parameter logic [31:0] CPU_ID   = 32'h0001_9300,
    parameter int          TID_W    = $clog2(NTHREADS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TID_W-1:0]    tid,
    input  logic [4:0]          reg_num,
    input  logic [2:0]          reg_sel,
    input  logic                wr_en,
    input  logic                raw_wr,
    input  logic [31:0]         wdata,
    input  logic                rd_en,
    output logic [31:0]         rdata,
    output logic [NTHREADS-1:0] run_en
);
    localparam int VE_W = (NVES > 1) ? $clog2(NVES) : 1;

    typedef struct packed {
        logic [N_SHARED-1:0][31:0]               sh;
        logic [NTHREADS-1:0][N_THREAD-1:0][31:0] thr;
        logic [NVES-1:0][N_VEREG-1:0][31:0]      ve;
        logic [31:0]                             rdata;
        logic                                    eval;
        logic [NTHREADS-1:0]                     run;
    } st_t;

    st_t st_q, st_d, st_rst;

    slot_t               slot;
    logic [VE_W-1:0]     bind_ve;
    logic [31:0]         cur;
    logic [31:0]         merged;
    logic                impl;
    logic [NTHREADS-1:0] act_v, stop_v, run_nx;

    cop_slot_decode u_dec (.reg_num(reg_num), .reg_sel(reg_sel), .slot(slot));

    cop_mask_merge #(.DW(32)) u_merge (
        .cur(cur), .wdata(wdata), .mask(slot.mask), .raw(raw_wr), .merged(merged)
    );

    always_comb begin
        for (int t = 0; t < NTHREADS; t++) begin
            act_v[t]  = st_q.thr[t][TH_STATE][ACT_BIT];
            stop_v[t] = st_q.thr[t][TH_STOP][STOP_BIT];
        end
    end

    cop_run_eval #(.NTHREADS(NTHREADS)) u_run (
        .eval(st_q.eval), .last_tid(st_q.sh[SH_TOPO][7:0]),
        .act(act_v), .stop(stop_v), .run_q(st_q.run), .run_d(run_nx)
    );

    assign impl    = (slot.bank != BK_NONE);
    assign bind_ve = st_q.thr[tid][TH_BIND][VE_W-1:0];

    always_comb begin
        case (slot.bank)
            BK_SHARED: cur = st_q.sh[slot.idx];
            BK_THREAD: cur = st_q.thr[tid][slot.idx[2:0]];
            BK_VE:     cur = st_q.ve[bind_ve][slot.idx[1:0]];
            default:   cur = 32'h0;
        endcase
    end

    // reset image
    always_comb begin
        st_rst = '0;
        st_rst.sh[SH_RAND]  = 32'd63;
        st_rst.sh[SH_CPUID] = CPU_ID;
        st_rst.sh[SH_VBASE] = VBASE_RST;
        st_rst.sh[SH_TOPO]  = (32'(NVES - 1) << VE_LO) | 32'(NTHREADS - 1);
        for (int t = 0; t < NTHREADS; t++) begin
            st_rst.thr[t][TH_STATUS] = STATUS_RST;
            st_rst.thr[t][TH_STATE]  = (t == 0) ? (32'd1 << ACT_BIT) : (32'd1 << DYN_BIT);
        end
        st_rst.run[0] = 1'b1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.eval = 1'b0;
        st_d.run  = run_nx;
        if (wr_en && impl) begin
            st_d.eval = 1'b1;
            case (slot.bank)
                BK_SHARED: st_d.sh[slot.idx]                 = merged;
                BK_THREAD: st_d.thr[tid][slot.idx[2:0]]      = merged;
                BK_VE:     st_d.ve[bind_ve][slot.idx[1:0]]   = merged;
                default: ;
            endcase
        end
        if (rd_en) st_d.rdata = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign run_en = st_q.run;

endmodule

// File: rtl/cop_ctrl_regfile_chk.sv
module cop_ctrl_regfile_chk #(
    parameter int NTHREADS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                raw_wr,
    input logic                rd_en,
    input logic                impl,
    input logic [31:0]         wdata,
    input logic [31:0]         mask,
    input logic [31:0]         cur,
    input logic [31:0]         merged,
    input logic [31:0]         rdata,
    input logic [NTHREADS-1:0] run_en
);
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !raw_wr && impl) |-> (((merged ^ cur) & ~mask) == 32'h0)); // R2

    AST_MASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !raw_wr && impl) |-> (((merged ^ wdata) & mask) == 32'h0)); // R1

    AST_RAW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && raw_wr && impl) |-> (merged == wdata)); // R3

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !impl) |=> (rdata == 32'h0)); // R10

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11

    AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && impl) |=> ##1 $stable(run_en)); // R8
endmodule

bind cop_ctrl_regfile cop_ctrl_regfile_chk #(.NTHREADS(NTHREADS)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .raw_wr(raw_wr), .rd_en(rd_en),
    .impl(impl), .wdata(wdata), .mask(slot.mask), .cur(cur), .merged(merged),
    .rdata(rdata), .run_en(run_en)
);

// File: tb/cop_ctrl_regfile_tb_top.sv
module cop_ctrl_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NV = 2;
    localparam logic [31:0] CPUID = 32'h0001_9300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    tid = '0;
    logic [4:0]    reg_num = '0;
    logic [2:0]    reg_sel = '0;
    logic          wr_en = 1'b0, raw_wr = 1'b0, rd_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NT-1:0] run_en;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [31:0]   m_sh  [256];
    logic [31:0]   m_thr [NT][256];
    logic [31:0]   m_ve  [NV][256];
    logic [NT-1:0] m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_ctrl_regfile #(.NTHREADS(NT), .NVES(NV), .CPU_ID(CPUID)) dut_i (
        .clk(clk), .rst_n(rst_n), .tid(tid), .reg_num(reg_num), .reg_sel(reg_sel),
        .wr_en(wr_en), .raw_wr(raw_wr), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .run_en(run_en)
    );

    // bank: 0 none, 1 shared, 2 per thread, 3 per VE
    function automatic int b_bank(input int f);
        case (f)
            0, 2, 8, 41, 97, 98, 120, 121, 128, 129, 130, 131: return 1;
            96, 17, 18, 20, 136, 184: return 2;
            9, 10, 49: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] b_mask(input int f);
        case (f)
            0:   return 32'h7FFF_FFFF;
            41:  return 32'h1000_0000;
            97:  return 32'h0000_03E0;
            98:  return 32'h0000_F3C0;
            121: return 32'h3FFF_F000;
            128: return 32'h7FFF_0007;
            130: return 32'h7000_F000;
            96:  return 32'hFF78_FF17;
            2, 8, 120, 129, 131: return 32'h0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int b_ve(input int t);
        return int'(m_thr[t][18][0]);
    endfunction

    function automatic logic [31:0] b_get(input int t, input int f);
        case (b_bank(f))
            1: return m_sh[f];
            2: return m_thr[t][f];
            3: return m_ve[b_ve(t)][f];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int f = 0; f < 256; f++) begin
            m_sh[f] = 0;
            for (int t = 0; t < NT; t++) m_thr[t][f] = 0;
            for (int v = 0; v < NV; v++) m_ve[v][f] = 0;
        end
        m_sh[2]   = (32'(NV - 1) << 10) | 32'(NT - 1);
        m_sh[8]   = 32'd63;
        m_sh[120] = CPUID;
        m_sh[121] = 32'h8000_0000;
        for (int t = 0; t < NT; t++) begin
            m_thr[t][96] = 32'h1040_0004;
            m_thr[t][17] = (t == 0) ? 32'h2000 : 32'h8000;
        end
        m_run = 4'b0001;
    endtask

    task automatic do_wr(input int t, input int f, input logic [31:0] v, input bit raw, input string req);
        logic [31:0] old, nv;
        logic [NT-1:0] pre;
        old = b_get(t, f);
        nv  = raw ? v : ((v & b_mask(f)) | (old & ~b_mask(f)));
        tid = 2'(t); reg_num = 5'(f >> 3); reg_sel = 3'(f); wdata = v; raw_wr = raw; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; raw_wr = 1'b0;
        case (b_bank(f))
            1: m_sh[f] = nv;
            2: m_thr[t][f] = nv;
            3: m_ve[b_ve(t)][f] = nv;
            default: ;
        endcase
        pre = m_run;
        chk(run_en == pre, {req, "/R8 run_en one cycle after write"}, 32'(run_en), 32'(pre));
        @(negedge clk);
        if (b_bank(f) != 0) begin
            for (int k = 0; k < NT; k++)
                if (k <= int'(m_sh[2][7:0]))
                    m_run[k] = m_thr[k][17][13] && !m_thr[k][20][0];
        end
        chk(run_en == m_run, {req, "/R8 run_en after evaluation"}, 32'(run_en), 32'(m_run));
    endtask

    task automatic do_rd(input int t, input int f, input string req);
        logic [31:0] exp;
        exp = b_get(t, f);
        tid = 2'(t); reg_num = 5'(f >> 3); reg_sel = 3'(f); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rdata === exp, req, rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    int flats [22] = '{0, 2, 8, 9, 10, 17, 18, 20, 41, 49, 96, 97, 98, 120, 121,
                       128, 129, 130, 131, 136, 184, 7};

    initial begin
        logic [31:0] keep;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset run state and thread states
        chk(run_en == 4'b0001, "R7 reset run_en", 32'(run_en), 32'h1);
        for (int t = 0; t < NT; t++) begin
            do_rd(t, 96, "R6 status reset");
            do_rd(t, 17, "R7 thread state reset");
        end
        do_rd(0, 121, "R6 vector base reset");
        do_rd(0, 8,   "R6 random index reset");
        do_rd(0, 2,   "R6 topology reset");
        do_rd(0, 120, "R6 cpu id reset");

        // R1 masked writes
        do_wr(1, 96, 32'hFFFF_FFFF, 1'b0, "R1");
        do_rd(1, 96, "R1 status all-ones masked");
        do_wr(0, 97, 32'hFFFF_FFFF, 1'b0, "R1");
        do_rd(0, 97, "R1 irq control masked");
        do_wr(0, 121, 32'h0000_0000, 1'b0, "R1");
        do_rd(0, 121, "R1 vector base keeps bit31");

        // R2 read-only, R3 raw
        do_wr(0, 129, 32'hDEAD_BEEF, 1'b0, "R2");
        do_rd(0, 129, "R2 cfg1 unchanged");
        do_wr(2, 8, 32'h0000_0011, 1'b0, "R2");
        do_rd(2, 8, "R2 random index unchanged");
        do_wr(0, 129, 32'hDEAD_BEEF, 1'b1, "R3");
        do_rd(0, 129, "R3 raw write cfg1");

        // R4 per-thread copies
        do_wr(2, 136, 32'h1234_5678, 1'b0, "R4");
        do_rd(2, 136, "R4 link addr thread 2");
        do_rd(0, 136, "R4 link addr thread 0 untouched");

        // R5 per-VE copies through binding
        do_wr(1, 18, 32'h0000_0001, 1'b0, "R5");
        do_wr(1, 9, 32'hAAAA_0001, 1'b0, "R5");
        do_wr(0, 9, 32'h5555_0000, 1'b0, "R5");
        do_rd(1, 9, "R5 VE1 copy via thread 1");
        do_rd(0, 9, "R5 VE0 copy via thread 0");
        do_rd(3, 9, "R5 thread 3 bound to VE0");

        // R10 unimplemented slots
        do_wr(0, 255, 32'hFFFF_FFFF, 1'b0, "R10");
        do_rd(0, 255, "R10 unimplemented slot reads zero");
        do_rd(0, 7, "R10 unimplemented slot 7");

        // R11 read holds and read-before-write
        do_rd(0, 121, "R11 read vector base");
        keep = rdata;
        do_wr(0, 121, 32'h1111_1000, 1'b0, "R11");
        chk(rdata == keep, "R11 rdata holds without read", rdata, keep);
        keep = b_get(0, 136);
        tid = 2'd0; reg_num = 5'd17; reg_sel = 3'd0; wdata = 32'h9999_9999;
        rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        m_thr[0][136] = 32'h9999_9999;
        chk(rdata == keep, "R11 same-cycle read returns old value", rdata, keep);
        @(negedge clk);

        // R8 run rule
        do_wr(1, 17, 32'h0000_2000, 1'b0, "R8");
        chk(run_en[1] == 1'b1, "R8 thread 1 runs when active", 32'(run_en), 32'h3);
        do_wr(0, 20, 32'h0000_0001, 1'b0, "R8");
        chk(run_en[0] == 1'b0, "R8 thread 0 halts on stop bit", 32'(run_en), 32'h2);
        do_wr(0, 20, 32'h0000_0000, 1'b0, "R8");

        // R9 reduced thread range
        do_wr(0, 2, 32'h0000_0401, 1'b1, "R9");
        do_wr(3, 17, 32'h0000_2000, 1'b0, "R9");
        chk(run_en[3] == 1'b0, "R9 thread 3 outside range keeps run_en", 32'(run_en), 32'(m_run));
        do_wr(0, 2, 32'h0000_0403, 1'b1, "R9");
        chk(run_en[3] == 1'b1, "R9 thread 3 evaluated after range restored", 32'(run_en), 32'(m_run));

        // random mix
        for (int i = 0; i < 400; i++) begin
            int f, t;
            f = flats[$urandom_range(0, 21)];
            t = $urandom_range(0, NT - 1);
            if (f == 2) do_wr(t, f, 32'(($urandom & 32'h3C00) | $urandom_range(0, NT - 1)),
                              ($urandom_range(0, 3) == 0), "R9");
            else        do_wr(t, f, $urandom, ($urandom_range(0, 9) == 0), "R1");
            do_rd($urandom_range(0, NT - 1), f, "R4 random read-back");
        end

        finish_run();
    end
endmodule